// File: doc/BRIEF.md
# Configuration Start-Up Release Sequencer

This block moves a programmable device from configuration mode into user mode once configuration data has finished loading. It runs on the configuration clock. After a done condition is seen, it walks a three-bit step counter from step 0 to step 7. It releases three global controls at the steps chosen for them: the output tristate hold, the global set/reset hold and the global write inhibit. Once all three have been released, it raises a status output.

Two options shape when the sequence runs. With the multi-device option on, the local done indication counts only while a shared wired-AND done line is also high, so every device on that line starts up together. With the lock-wait option on, the counter stops at a selected step until every clock-management loop picked by a mask reports lock.

Top module: `startup_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `tristateHold`, `setResetHold` and `writeInhibit` to 1, clears `startDone` and returns the step counter to step 0.
- R2: The edge at which the done condition is first true is step 0. Each further unstalled edge is the next step. A control whose select equals step s is released (its output goes to 0) at the step-s edge. With selects 1 / 2 / 2, the tristate hold drops one cycle after the done condition is seen and the other two drop one cycle later.
- R3: Each of `tristateSel`, `setResetSel` and `writeEnSel` is a 3-bit step number (0..7) and is chosen independently of the others.
- R4: When `syncDoneEn` is 1, the done condition is `doneLocal` AND `doneWired`. `doneLocal` alone then starts nothing.
- R5: When `lockWaitEn` is 1 and the counter is at step `lockStep`, the counter holds and no further control is released until every loop whose `lockMask` bit is 1 has its `loopLock` bit at 1. Loops with a mask bit of 0 are ignored.
- R6: A released control stays released until the next reset, whatever the done inputs do afterwards.
- R7: `startDone` is 1 exactly when all three controls are released.
- R8: Until the done condition has been seen, no control is released.
- R9: The step counter saturates at step 7, so a select of 7 is released at the step-7 edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous configuration reset, active high |
| doneLocal | input | 1 | This device's done indication |
| doneWired | input | 1 | Sensed shared wired-AND done line |
| syncDoneEn | input | 1 | 1: also require the shared done line |
| lockWaitEn | input | 1 | 1: stall at `lockStep` until the masked loops lock |
| lockStep | input | 3 | Step at which the lock wait applies |
| lockMask | input | NUM_LOOPS | Loops that must report lock |
| loopLock | input | NUM_LOOPS | Lock flag of each clock loop |
| tristateSel | input | 3 | Release step of the output tristate hold |
| setResetSel | input | 3 | Release step of the set/reset hold |
| writeEnSel | input | 3 | Release step of the write inhibit |
| tristateHold | output | 1 | 1: device outputs held in tristate |
| setResetHold | output | 1 | 1: global set/reset asserted |
| writeInhibit | output | 1 | 1: storage writes blocked |
| startDone | output | 1 | All three controls released |

## Verification
A step counter that is off by one, or that moves during a lock stall, shows at the ports as a control releasing one edge early or late. That error is visible in the first sample after the affected step edge. A release flag that is not sticky, or a done condition that ignores the shared line, shows as a hold output changing at a step where the select values say it must not. The bench samples all four outputs after every step edge from step 0 to step 8, so any such fault is caught within one cycle of the step where it occurs.

// File: rtl/startup_seq_pkg.sv
package startup_seq_pkg;
  localparam int STEP_W = 3;
  localparam int NUM_CTRL = 3;

  typedef struct packed {
    logic fire;
    logic [STEP_W-1:0] step;
  } stepStrobe_t;
endpackage

// File: rtl/startup_seq_ctrl.sv
module startup_seq_ctrl
  import startup_seq_pkg::*;
#(
  parameter int NUM_LOOPS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 doneLocal,
  input  logic                 doneWired,
  input  logic                 syncDoneEn,
  input  logic                 lockWaitEn,
  input  logic [STEP_W-1:0]    lockStep,
  input  logic [NUM_LOOPS-1:0] lockMask,
  input  logic [NUM_LOOPS-1:0] loopLock,
  output stepStrobe_t          strobe
);
  localparam logic [STEP_W-1:0] LAST_STEP = '1;

  logic active;
  logic [STEP_W-1:0] stepCnt;
  logic doneCond;
  logic valid;
  logic locksOk;
  logic stall;
  logic [STEP_W-1:0] curStep;
  logic [STEP_W-1:0] nextStep;

  // done condition, optionally qualified by the shared line
  assign doneCond = doneLocal && (!syncDoneEn || doneWired);
  assign valid    = active || doneCond;
  assign curStep  = active ? stepCnt : '0;
  assign locksOk  = &(loopLock | ~lockMask);
  assign stall    = valid && lockWaitEn && (curStep == lockStep) && !locksOk;
  assign nextStep = (curStep == LAST_STEP) ? LAST_STEP : curStep + STEP_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      stepCnt <= '0;
    end else if (valid) begin
      active  <= 1'b1;
      stepCnt <= stall ? curStep : nextStep;
    end
  end

  assign strobe.fire = valid && !stall;
  assign strobe.step = curStep;

  // R5: a lock stall freezes the counter
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (active && stall) |=> (stepCnt == $past(stepCnt)));

  // R8: without a done condition the sequencer stays idle
  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (!active && !doneCond) |=> (!active && stepCnt == '0));

  // R9: the counter saturates at the last step
  p_saturate_r9: assert property (@(posedge clk) disable iff (rst)
    (active && stepCnt == LAST_STEP) |=> (stepCnt == LAST_STEP));
endmodule

// File: rtl/startup_seq_datapath.sv
module startup_seq_datapath
  import startup_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  stepStrobe_t       strobe,
  input  logic [STEP_W-1:0] tristateSel,
  input  logic [STEP_W-1:0] setResetSel,
  input  logic [STEP_W-1:0] writeEnSel,
  output logic              tristateHold,
  output logic              setResetHold,
  output logic              writeInhibit
);
  logic [STEP_W-1:0] selArr [NUM_CTRL];
  logic [NUM_CTRL-1:0] released;

  assign selArr[0] = tristateSel;
  assign selArr[1] = setResetSel;
  assign selArr[2] = writeEnSel;

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrl
    always_ff @(posedge clk) begin
      if (rst) begin
        released[i] <= 1'b0;
      end else if (strobe.fire && (strobe.step == selArr[i])) begin
        released[i] <= 1'b1;
      end
    end

    // R6: a release is sticky until reset
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
      released[i] |=> released[i]);
  end

  assign tristateHold = !released[0];
  assign setResetHold = !released[1];
  assign writeInhibit = !released[2];

  // R1: reset puts every control back into its held state
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (released == '0));

  // R5 R8: without a step strobe nothing new is released
  p_no_fire_r8: assert property (@(posedge clk) disable iff (rst)
    !strobe.fire |=> $stable(released));
endmodule

// File: rtl/startup_seq.sv
module startup_seq
  import startup_seq_pkg::*;
#(
  parameter int NUM_LOOPS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 doneLocal,
  input  logic                 doneWired,
  input  logic                 syncDoneEn,
  input  logic                 lockWaitEn,
  input  logic [2:0]           lockStep,
  input  logic [NUM_LOOPS-1:0] lockMask,
  input  logic [NUM_LOOPS-1:0] loopLock,
  input  logic [2:0]           tristateSel,
  input  logic [2:0]           setResetSel,
  input  logic [2:0]           writeEnSel,
  output logic                 tristateHold,
  output logic                 setResetHold,
  output logic                 writeInhibit,
  output logic                 startDone
);
  stepStrobe_t strobe;

  startup_seq_ctrl #(.NUM_LOOPS(NUM_LOOPS)) ctrl_i (
    .clk(clk), .rst(rst),
    .doneLocal(doneLocal), .doneWired(doneWired), .syncDoneEn(syncDoneEn),
    .lockWaitEn(lockWaitEn), .lockStep(lockStep),
    .lockMask(lockMask), .loopLock(loopLock),
    .strobe(strobe)
  );

  startup_seq_datapath dp_i (
    .clk(clk), .rst(rst), .strobe(strobe),
    .tristateSel(tristateSel), .setResetSel(setResetSel), .writeEnSel(writeEnSel),
    .tristateHold(tristateHold), .setResetHold(setResetHold),
    .writeInhibit(writeInhibit)
  );

  assign startDone = !tristateHold && !setResetHold && !writeInhibit;

  // R7: once complete, start-up stays complete until reset
  p_done_stays_r7: assert property (@(posedge clk) disable iff (rst)
    startDone |=> startDone);
endmodule

// File: tb/startup_seq_tb_top.sv
module startup_seq_tb_top;
  localparam int NL = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic doneLocal = 1'b0, doneWired = 1'b0, syncDoneEn = 1'b0, lockWaitEn = 1'b0;
  logic [2:0] lockStep = 3'd0;
  logic [NL-1:0] lockMask = '0, loopLock = '0;
  logic [2:0] tristateSel = 3'd1, setResetSel = 3'd2, writeEnSel = 3'd2;
  logic tristateHold, setResetHold, writeInhibit, startDone;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  startup_seq #(.NUM_LOOPS(NL)) dut_i (
    .clk(clk), .rst(rst), .doneLocal(doneLocal), .doneWired(doneWired),
    .syncDoneEn(syncDoneEn), .lockWaitEn(lockWaitEn), .lockStep(lockStep),
    .lockMask(lockMask), .loopLock(loopLock),
    .tristateSel(tristateSel), .setResetSel(setResetSel), .writeEnSel(writeEnSel),
    .tristateHold(tristateHold), .setResetHold(setResetHold),
    .writeInhibit(writeInhibit), .startDone(startDone)
  );

  // {tristateSel, setResetSel, writeEnSel}
  localparam logic [8:0] VEC [6] = '{
    {3'd1, 3'd2, 3'd2}, {3'd0, 3'd0, 3'd0}, {3'd2, 3'd1, 3'd3},
    {3'd7, 3'd5, 3'd0}, {3'd3, 3'd3, 3'd7}, {3'd4, 3'd6, 3'd1}
  };

  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {tristateHold, setResetHold, writeInhibit, startDone};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] expAt(input int k, input logic [2:0] t,
                                       input logic [2:0] s, input logic [2:0] w);
    logic a, b, c;
    a = k < int'(t);
    b = k < int'(s);
    c = k < int'(w);
    return {a, b, c, !(a || b || c)};
  endfunction

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    doneLocal = 1'b0; doneWired = 1'b0;
    syncDoneEn = 1'b0; lockWaitEn = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 R8: reset state, idle without done
    repeat (2) @(negedge clk);
    chk("R1 reset", 4'b1110);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 idle no done", 4'b1110);

    // R2 R3 R7 R9: step table
    for (int v = 0; v < 6; v++) begin
      doReset();
      {tristateSel, setResetSel, writeEnSel} = VEC[v];
      doneLocal = 1'b1;
      for (int k = 0; k <= 8; k++) begin
        @(negedge clk);
        chk(v == 0 ? "R2 default" : (v == 3 || v == 4) ? "R3 R9 R7" : "R3 R7",
            expAt(k, tristateSel, setResetSel, writeEnSel));
      end
    end

    // R4: shared done line gates the local done
    doReset();
    {tristateSel, setResetSel, writeEnSel} = {3'd1, 3'd2, 3'd2};
    syncDoneEn = 1'b1;
    doneLocal = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4 wired low", 4'b1110);
    doneWired = 1'b1;
    @(negedge clk);
    chk("R4 step0", 4'b1110);
    @(negedge clk);
    chk("R4 step1", 4'b0110);
    @(negedge clk);
    chk("R4 step2", 4'b0001);

    // R6: done inputs dropping leaves the released state
    doneLocal = 1'b0; doneWired = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 sticky", 4'b0001);

    // R5: stall at step 1; unmasked loops locked, masked ones not
    doReset();
    lockWaitEn = 1'b1;
    lockStep = 3'd1;
    lockMask = 4'b0011;
    loopLock = 4'b1100;
    doneLocal = 1'b1;
    @(negedge clk);
    chk("R5 step0", 4'b1110);
    repeat (5) @(negedge clk);
    chk("R5 stalled", 4'b1110);
    loopLock = 4'b0011;
    @(negedge clk);
    chk("R5 lock step1", 4'b0110);
    @(negedge clk);
    chk("R5 lock step2", 4'b0001);

    // R5: stall at step 2 keeps tristate released but holds the rest
    doReset();
    lockStep = 3'd2;
    loopLock = 4'b0001;
    lockWaitEn = 1'b1;
    doneLocal = 1'b1;
    repeat (6) @(negedge clk);
    chk("R5 partial stall", 4'b0110);
    loopLock = 4'b1111;
    @(negedge clk);
    chk("R5 partial release", 4'b0001);

    // R1: reset after completion restores the held state
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset after done", 4'b1110);
    rst = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule